// File: doc/BRIEF.md
# Configurable External Interrupt Edge Detector

The block converts 24 asynchronous external lines into interrupt request bits. Sixteen of them are general-purpose port lines and eight are dedicated interrupt lines. Every line goes through a synchronizer and a history stage, so a change on the line is seen as a difference between two successive synchronized samples. Each line has a mode bit in a control word. A port line uses the bit to choose between catching every change and catching only falling changes. An interrupt line uses it to choose between an active-low level request and a falling-edge request.

Edge requests are latched in a pending bit that stays set until software writes a one to that bit. A level request follows the pin directly. An enable word gates the pending bits, and the gated bits are ORed into one registered request output. Software reaches the mode, pending and enable words through a small word-wide register port. The port has a write strobe and a read path with one cycle of latency.

Top module: `xirq_detect`

## Requirements
- R1: Latency. A pin level driven before clock edge k is captured at edge k. If it forms a qualifying change, the pending bit is set at edge k+2. A read issued at edge k+3 returns the bit, and `irq_out` reflects it after edge k+3.
- R2: A port line whose mode bit is 0 sets its pending bit on both rising and falling changes.
- R3: A port line whose mode bit is 1 sets its pending bit only on a high-to-low change. Rising changes leave the bit unchanged.
- R4: Register layout. Address 0 holds the mode word, 1 the pending word and 2 the enable word. Address 3 reads zero. In all three words, port line i sits at `reg_wdata`/`reg_rdata` bit 31-i and interrupt line j at bit 15-j. `reg_rdata` returns the word addressed at the previous clock edge.
- R5: An interrupt line whose mode bit is 0 has a pending bit that tracks its synchronized low level, with the same latency as R1. Writing a one to clear it has no effect while the line stays low.
- R6: An interrupt line whose mode bit is 1 sets its pending bit only on a high-to-low change. The bit stays set after the line returns high.
- R7: Bits 7:0 of every word read as zero, and writes to those bits are discarded.
- R8: Reset is synchronous and active high. It clears the mode, pending and enable words and `irq_out`, and presets all synchronizer stages to high, so that an idle-high line causes no request after reset.
- R9: A write of ones to address 1 clears the selected edge-mode pending bits at the next edge. Bits written as zero are not changed.
- R10: If a qualifying edge is detected in the same cycle as a clear of that bit, the bit stays set.
- R11: `irq_out` is high exactly when, at the previous edge, at least one pending bit had its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Word select: 0 mode, 1 pending, 2 enable |
| reg_wr | input | 1 | Write strobe for the addressed word |
| reg_wdata | input | 32 | Write data (pending: write one to clear) |
| reg_rdata | output | 32 | Registered read data of the addressed word |
| port_pins | input | 16 | Asynchronous general-purpose port lines |
| irq_pins | input | 8 | Asynchronous dedicated interrupt lines |
| irq_out | output | 1 | Registered OR of the enabled pending bits |

## Verification
Random pin activity and register traffic run in lockstep with a cycle-level model in the bench, and directed cases target the corner cases. Each case and the fault it exposes:
- A clear issued in the very cycle a new edge is detected. A design that lets the clear win loses that request.
- A clear attempted on a level-mode line while the line is held low. A design that lets it succeed drops an active request.
- Rising changes on a falling-only line. A design that treats them as edges raises requests that were not asked for.
- A write of all ones to the mode word, which shows whether the reserved low byte reads back as zero.
- Cycle-exact comparison of every read and of `irq_out`, which catches a missing or extra pipeline stage.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  typedef enum logic [1:0] {
    ADR_MODE = 2'd0,
    ADR_PEND = 2'd1,
    ADR_ENAB = 2'd2,
    ADR_NONE = 2'd3
  } xirq_addr_e;
endpackage

// File: rtl/xirq_sync.sv
// Two-flop synchronizer plus one history stage per line; preset high.
module xirq_sync #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] stg1, stg2, stg3;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg1 <= '1;
      stg2 <= '1;
      stg3 <= '1;
    end else begin
      stg1 <= pin_in;
      stg2 <= stg1;
      stg3 <= stg2;
    end
  end

  assign cur  = stg2;
  assign prev = stg3;
endmodule

// File: rtl/xirq_cell.sv
// One line: edge qualification by group and mode, plus the pending flop.
module xirq_cell #(
  parameter bit IS_PORT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic cur,
  input  logic prev,
  input  logic mode,
  input  logic clr,
  output logic pend
);
  logic hit;
  logic level_mode;

  generate
    if (IS_PORT) begin : g_port
      assign hit        = mode ? (prev & ~cur) : (prev ^ cur);
      assign level_mode = 1'b0;
    end else begin : g_irq
      assign hit        = prev & ~cur;
      assign level_mode = ~mode;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)             pend <= 1'b0;
    else if (level_mode) pend <= ~cur;
    else                 pend <= (pend & ~clr) | hit;
  end
endmodule

// File: rtl/xirq_regs.sv
// Mode and enable storage, one-to-clear decode, registered read mux.
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int NPORT = 16,
  parameter int NIRQ  = 8,
  parameter int DW    = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             reg_addr,
  input  logic                   reg_wr,
  input  logic [DW-1:0]          reg_wdata,
  input  logic [NPORT+NIRQ-1:0]  pend_lines,
  output logic [NPORT+NIRQ-1:0]  mode_lines,
  output logic [NPORT+NIRQ-1:0]  en_lines,
  output logic [NPORT+NIRQ-1:0]  clr_lines,
  output logic [DW-1:0]          reg_rdata
);
  localparam int NLINE = NPORT + NIRQ;
  localparam int NRSV  = DW - NLINE;

  xirq_addr_e      sel;
  logic [NLINE-1:0] wr_lines;
  logic             wdata_unused;

  assign sel = xirq_addr_e'(reg_addr);

  genvar gi;
  generate
    for (gi = 0; gi < NLINE; gi++) begin : g_unpack
      assign wr_lines[gi] = reg_wdata[DW-1-gi];
    end
  endgenerate
  assign wdata_unused = ^reg_wdata[NRSV-1:0];

  function automatic logic [DW-1:0] pack_word(input logic [NLINE-1:0] v);
    logic [DW-1:0] w;
    w = '0;
    for (int i = 0; i < NLINE; i++) w[DW-1-i] = v[i];
    return w;
  endfunction

  assign clr_lines = (reg_wr && sel == ADR_PEND) ? wr_lines : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_lines <= '0;
      en_lines   <= '0;
    end else if (reg_wr) begin
      if (sel == ADR_MODE) mode_lines <= wr_lines;
      if (sel == ADR_ENAB) en_lines   <= wr_lines;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (sel)
        ADR_MODE: reg_rdata <= pack_word(mode_lines);
        ADR_PEND: reg_rdata <= pack_word(pend_lines);
        ADR_ENAB: reg_rdata <= pack_word(en_lines);
        default:  reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect #(
  parameter int NPORT = 16,
  parameter int NIRQ  = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NPORT-1:0] port_pins,
  input  logic [NIRQ-1:0]  irq_pins,
  output logic             irq_out
);
  localparam int NLINE = NPORT + NIRQ;

  logic [NLINE-1:0] pin_lines, cur_lines, prev_lines;
  logic [NLINE-1:0] mode_lines, en_lines, clr_lines, pend_lines;

  assign pin_lines = {irq_pins, port_pins};

  xirq_sync #(.W(NLINE)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_in(pin_lines),
    .cur   (cur_lines),
    .prev  (prev_lines)
  );

  genvar g;
  generate
    for (g = 0; g < NLINE; g++) begin : g_line
      xirq_cell #(.IS_PORT(g < NPORT ? 1'b1 : 1'b0)) u_cell (
        .clk (clk),
        .rst (rst),
        .cur (cur_lines[g]),
        .prev(prev_lines[g]),
        .mode(mode_lines[g]),
        .clr (clr_lines[g]),
        .pend(pend_lines[g])
      );
    end
  endgenerate

  xirq_regs #(.NPORT(NPORT), .NIRQ(NIRQ), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .pend_lines(pend_lines),
    .mode_lines(mode_lines),
    .en_lines  (en_lines),
    .clr_lines (clr_lines),
    .reg_rdata (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(pend_lines & en_lines);
  end
endmodule

// File: rtl/xirq_check.sv
module xirq_check #(
  parameter int NPORT = 16,
  parameter int NIRQ  = 8,
  parameter int DW    = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NPORT+NIRQ-1:0] mode_lines,
  input logic [NPORT+NIRQ-1:0] en_lines,
  input logic [NPORT+NIRQ-1:0] pend_lines,
  input logic [NPORT+NIRQ-1:0] cur_lines,
  input logic [NPORT+NIRQ-1:0] clr_lines,
  input logic [DW-1:0]         reg_rdata,
  input logic                  irq_out
);
  localparam int NLINE = NPORT + NIRQ;
  logic [NLINE-1:0] lvl;

  genvar gi;
  generate
    for (gi = 0; gi < NLINE; gi++) begin : g_lvl
      if (gi < NPORT) begin : g_p
        assign lvl[gi] = 1'b0;
      end else begin : g_i
        assign lvl[gi] = ~mode_lines[gi];
      end
    end
  endgenerate

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DW-NLINE-1:0] == '0); // R7

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (mode_lines == '0 && en_lines == '0 && pend_lines == '0 && !irq_out)); // R8

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_lines ^ ~$past(cur_lines)) & $past(lvl)) == '0); // R5

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($past(pend_lines & ~lvl & ~clr_lines) & ~pend_lines) == '0); // R9

  AST_OUT_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|(pend_lines & en_lines))); // R11
endmodule

bind xirq_detect xirq_check #(.NPORT(NPORT), .NIRQ(NIRQ), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_lines(mode_lines),
  .en_lines  (en_lines),
  .pend_lines(pend_lines),
  .cur_lines (cur_lines),
  .clr_lines (clr_lines),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out)
);

// File: tb/xirq_detect_test.sv
module xirq_detect_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = 2'd1;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] port_pins = '1;
  logic [7:0]  irq_pins = '1;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R8";

  // model state, line-indexed: 0..15 port lines, 16..23 interrupt lines
  logic [23:0] m1, m2, m3, mpend, men, mmode;
  logic        mirq;
  logic [31:0] mrd;

  always #10 clk = ~clk;

  xirq_detect uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .port_pins(port_pins), .irq_pins(irq_pins), .irq_out(irq_out)
  );

  function automatic logic [23:0] lines_of(input logic [31:0] w);
    logic [23:0] l;
    for (int i = 0; i < 24; i++) l[i] = w[31-i];
    return l;
  endfunction

  function automatic logic [31:0] word_of(input logic [23:0] l);
    logic [31:0] w = '0;
    for (int i = 0; i < 24; i++) w[31-i] = l[i];
    return w;
  endfunction

  task automatic model_reset();
    m1 = '1; m2 = '1; m3 = '1;
    mpend = '0; men = '0; mmode = '0; mirq = 1'b0; mrd = '0;
  endtask

  task automatic model_edge();
    logic [23:0] npend, clr;
    logic e;
    clr = (reg_wr && reg_addr == 2'd1) ? lines_of(reg_wdata) : '0;
    for (int i = 0; i < 24; i++) begin
      if (i < 16) e = mmode[i] ? (m3[i] & ~m2[i]) : (m3[i] ^ m2[i]);
      else        e = m3[i] & ~m2[i];
      if (i >= 16 && !mmode[i]) npend[i] = ~m2[i];
      else                      npend[i] = (mpend[i] & ~clr[i]) | e;
    end
    mirq = |(mpend & men);
    case (reg_addr)
      2'd0: mrd = word_of(mmode);
      2'd1: mrd = word_of(mpend);
      2'd2: mrd = word_of(men);
      default: mrd = '0;
    endcase
    m3 = m2; m2 = m1; m1 = {irq_pins, port_pins};
    if (reg_wr && reg_addr == 2'd0) mmode = lines_of(reg_wdata);
    if (reg_wr && reg_addr == 2'd2) men = lines_of(reg_wdata);
    mpend = npend;
  endtask

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: inputs already set at negedge
  task automatic step(input logic wr, input logic [1:0] a, input logic [31:0] wd);
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    model_edge();
    #5;
    check(reg_rdata === mrd, "rdata", reg_rdata, mrd);
    check(irq_out === mirq, "irq_out", {31'b0, irq_out}, {31'b0, mirq});
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic [1:0] a);
    for (int k = 0; k < n; k++) step(1'b0, a, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tag = "watchdog";
    total++; bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    tag = "R8";  idle(2, 2'd0); idle(2, 2'd1); idle(2, 2'd2);

    tag = "R7";  step(1'b1, 2'd0, 32'hFFFF_FFFF); idle(2, 2'd0);
    tag = "R4";  step(1'b1, 2'd0, 32'h8000_8000); idle(2, 2'd0);
                 step(1'b1, 2'd2, 32'h1234_56FF); idle(2, 2'd2); idle(1, 2'd3);
                 step(1'b1, 2'd2, 32'h0); step(1'b1, 2'd0, 32'h0);

    tag = "R1";  port_pins[5] = 1'b0; idle(5, 2'd1);
    tag = "R2";  port_pins[5] = 1'b1; idle(4, 2'd1);
    tag = "R9";  step(1'b1, 2'd1, 32'h0400_0000); idle(2, 2'd1);
                 port_pins[5] = 1'b0; idle(4, 2'd1);
                 step(1'b1, 2'd1, 32'h0000_0000); idle(1, 2'd1);
                 step(1'b1, 2'd1, 32'hFFFF_FFFF); idle(2, 2'd1);

    tag = "R3";  step(1'b1, 2'd0, 32'h1000_0000); idle(1, 2'd1);
                 port_pins[3] = 1'b0; idle(3, 2'd1); port_pins[3] = 1'b1; idle(4, 2'd1);
                 step(1'b1, 2'd1, 32'h1000_0000); idle(1, 2'd1);
                 port_pins[3] = 1'b0; idle(4, 2'd1);
                 step(1'b1, 2'd1, 32'h1000_0000); idle(2, 2'd1);

    tag = "R10"; port_pins[5] = 1'b1; idle(2, 2'd1);
                 step(1'b1, 2'd1, 32'h0400_0000); idle(3, 2'd1);

    tag = "R5";  irq_pins[2] = 1'b0; idle(4, 2'd1);
                 step(1'b1, 2'd1, 32'h0000_2000); step(1'b1, 2'd1, 32'h0000_2000); idle(2, 2'd1);
                 irq_pins[2] = 1'b1; idle(4, 2'd1);

    tag = "R6";  step(1'b1, 2'd0, 32'h0000_2000); idle(1, 2'd1);
                 irq_pins[2] = 1'b0; idle(2, 2'd1); irq_pins[2] = 1'b1; idle(4, 2'd1);
                 step(1'b1, 2'd1, 32'h0000_2000); idle(2, 2'd1);

    tag = "R11"; port_pins[9] = 1'b0; idle(4, 2'd1);
                 step(1'b1, 2'd2, 32'h0000_2000); idle(3, 2'd1);
                 step(1'b1, 2'd2, 32'h0040_0000); idle(3, 2'd1);
                 step(1'b1, 2'd1, 32'hFFFF_FF00); idle(3, 2'd1);

    tag = "R2/R3/R5/R6/R9";
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] a;
      logic [31:0] d;
      if ($urandom_range(0, 7) == 0) port_pins[$urandom_range(0, 15)] ^= 1'b1;
      if ($urandom_range(0, 9) == 0) irq_pins[$urandom_range(0, 7)] ^= 1'b1;
      a = 2'($urandom_range(0, 3));
      d = $urandom;
      if ($urandom_range(0, 11) == 0) step(1'b1, a, d);
      else step(1'b0, ($urandom_range(0, 3) == 0) ? 2'd2 : 2'd1, '0);
    end

    finish_run();
  end
endmodule